// File: doc/BRIEF.md
# Oversampled UART Receive Deserialiser

This block turns an asynchronous serial line into bytes for a UART receive path. It runs on the system clock. A one-cycle enable marks each oversample tick, at sixteen ticks per bit. The line first passes through a synchroniser. A falling edge on the synchronised line arms a tick counter. The candidate start bit is checked again at its middle, and a line that has gone high again by then is treated as noise. In that case the block returns to idle and produces nothing.

Once a start bit is accepted, the block samples each data bit and then the stop bit, one per bit period, near the bit centre. Bits arrive least significant first. When the stop bit has been sampled, the byte goes out on a one-cycle push toward a receive FIFO, together with a framing-error flag and a break flag. The frame format is fixed: eight data bits, no parity and one stop bit. After a break the block waits for the line to return high before it looks for another start bit.

Top module: `uart_rx_deser`

## Requirements
- R1: `rx_serial` passes through two flip-flops clocked by `clk`, each reset to 1. A start is detected when the synchronised line goes from 1 to 0.
- R2: The start bit is sampled again on the 8th tick after the falling edge is detected. If it is 1, the event is dropped and nothing is pushed. With a tick on every clock, a low pulse of 8 clocks is rejected and one of 9 clocks is accepted.
- R3: After an accepted start, the block takes 8 data bits, one every 16 ticks, least significant bit first. `push_data[0]` is the first bit received.
- R4: Each character gives exactly one cycle with `push_valid`=1, in the clock after the tick on which the stop bit is sampled. `push_frame_err` and `push_break` are 0 whenever `push_valid` is 0.
- R5: `push_frame_err` is 1 with the push if the stop bit is sampled as 0, and 0 otherwise.
- R6: `push_break` is 1 with the push when all data bits and the stop bit are 0. A break always comes with `push_frame_err`=1 and `push_data`=0.
- R7: After a break, no new start is detected until the line has been seen high. A normal frame sent after that is received correctly.
- R8: The counters advance only on clocks where `os_tick`=1, so the block works with a tick enable that has gaps. A push only follows a clock with `os_tick`=1.
- R9: While `rst_n`=0, `push_valid`, `push_frame_err` and `push_break` are 0 and the receiver is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| os_tick | input | 1 | One-cycle oversample enable, 16 per bit |
| rx_serial | input | 1 | Asynchronous serial input, idle high |
| push_valid | output | 1 | One-cycle push of a received character |
| push_data | output | 8 | Received byte, LSB first on the line |
| push_frame_err | output | 1 | Stop bit was sampled as 0 |
| push_break | output | 1 | All data and stop bits were 0 |

## Verification
The assertions check the push contract on every cycle. A push lasts a single cycle and follows a tick. The flags stay at zero outside a push, and a break always arrives with a framing error and a zero byte. Only the bench scenarios can show the rest. That covers the exact length of glitch that is rejected or accepted, the bit order, the flag values for each stop-bit and data pattern, and operation with a gapped tick. It also covers the receiver re-arming after a break once the line returns high.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

    typedef enum logic [2:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_STOP,
        RX_BRKWAIT
    } rx_state_e;

endpackage

// File: rtl/uart_rx_sync.sv
// Input synchroniser (STAGES >= 2) followed by a falling-edge detector.
module uart_rx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_async,
    output logic line_sync,
    output logic line_fall
);

    typedef struct packed {
        logic [STAGES-1:0] chain;
        logic              prev;
    } sync_t;

    sync_t sync_d, sync_q;

    always_comb begin
        sync_d       = sync_q;
        sync_d.chain = {sync_q.chain[STAGES-2:0], line_async};
        sync_d.prev  = sync_q.chain[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '{chain: '1, prev: 1'b1};
        end else begin
            sync_q <= sync_d;
        end
    end

    assign line_sync = sync_q.chain[STAGES-1];
    assign line_fall = sync_q.prev & ~sync_q.chain[STAGES-1];

endmodule

// File: rtl/uart_rx_ctrl.sv
// Start validation, bit-centre sampling and character assembly.
module uart_rx_ctrl
    import uart_rx_pkg::*;
#(
    parameter int OVERSAMPLE = 16,
    parameter int DATA_BITS  = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 tick,
    input  logic                 line_sync,
    input  logic                 line_fall,
    output logic                 char_done,
    output logic                 stop_level,
    output logic [DATA_BITS-1:0] char_bits
);

    localparam int CW = $clog2(OVERSAMPLE);
    localparam int BW = $clog2(DATA_BITS + 1);
    localparam logic [CW-1:0] MID_LAST  = CW'(OVERSAMPLE / 2 - 1);
    localparam logic [CW-1:0] FULL_LAST = CW'(OVERSAMPLE - 1);
    localparam logic [BW-1:0] IDX_LAST  = BW'(DATA_BITS - 1);

    typedef struct packed {
        rx_state_e            st;
        logic [CW-1:0]        cnt;
        logic [BW-1:0]        idx;
        logic [DATA_BITS-1:0] shreg;
    } ctrl_t;

    ctrl_t ctrl_d, ctrl_q;

    always_comb begin
        ctrl_d    = ctrl_q;
        char_done = 1'b0;
        case (ctrl_q.st)
            RX_IDLE: begin
                if (line_fall) begin
                    ctrl_d.st  = RX_START;
                    ctrl_d.cnt = '0;
                end
            end
            RX_START: begin
                if (tick) begin
                    if (ctrl_q.cnt == MID_LAST) begin
                        ctrl_d.cnt = '0;
                        ctrl_d.idx = '0;
                        ctrl_d.st  = line_sync ? RX_IDLE : RX_DATA;
                    end else begin
                        ctrl_d.cnt = ctrl_q.cnt + 1'b1;
                    end
                end
            end
            RX_DATA: begin
                if (tick) begin
                    if (ctrl_q.cnt == FULL_LAST) begin
                        ctrl_d.cnt   = '0;
                        ctrl_d.shreg = {line_sync, ctrl_q.shreg[DATA_BITS-1:1]};
                        if (ctrl_q.idx == IDX_LAST) begin
                            ctrl_d.st = RX_STOP;
                        end else begin
                            ctrl_d.idx = ctrl_q.idx + 1'b1;
                        end
                    end else begin
                        ctrl_d.cnt = ctrl_q.cnt + 1'b1;
                    end
                end
            end
            RX_STOP: begin
                if (tick) begin
                    if (ctrl_q.cnt == FULL_LAST) begin
                        char_done  = 1'b1;
                        ctrl_d.cnt = '0;
                        if (!line_sync && (ctrl_q.shreg == '0)) begin
                            ctrl_d.st = RX_BRKWAIT;
                        end else begin
                            ctrl_d.st = RX_IDLE;
                        end
                    end else begin
                        ctrl_d.cnt = ctrl_q.cnt + 1'b1;
                    end
                end
            end
            RX_BRKWAIT: begin
                if (line_sync) begin
                    ctrl_d.st = RX_IDLE;
                end
            end
            default: ctrl_d.st = RX_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '{st: RX_IDLE, cnt: '0, idx: '0, shreg: '0};
        end else begin
            ctrl_q <= ctrl_d;
        end
    end

    assign stop_level = line_sync;
    assign char_bits  = ctrl_q.shreg;

endmodule

// File: rtl/uart_rx_push.sv
// Registers the completed character and forms the error flags.
module uart_rx_push #(
    parameter int DATA_BITS = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 char_done,
    input  logic                 stop_level,
    input  logic [DATA_BITS-1:0] char_bits,
    output logic                 out_valid,
    output logic [DATA_BITS-1:0] out_data,
    output logic                 out_ferr,
    output logic                 out_brk
);

    typedef struct packed {
        logic                 vld;
        logic [DATA_BITS-1:0] dat;
        logic                 ferr;
        logic                 brk;
    } push_t;

    push_t push_d, push_q;

    always_comb begin
        push_d      = push_q;
        push_d.vld  = char_done;
        push_d.ferr = char_done & ~stop_level;
        push_d.brk  = char_done & ~stop_level & (char_bits == '0);
        if (char_done) begin
            push_d.dat = char_bits;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            push_q <= '{vld: 1'b0, dat: '0, ferr: 1'b0, brk: 1'b0};
        end else begin
            push_q <= push_d;
        end
    end

    assign out_valid = push_q.vld;
    assign out_data  = push_q.dat;
    assign out_ferr  = push_q.ferr;
    assign out_brk   = push_q.brk;

endmodule

// File: rtl/uart_rx_deser.sv
module uart_rx_deser #(
    parameter int OVERSAMPLE  = 16,
    parameter int DATA_BITS   = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 os_tick,
    input  logic                 rx_serial,
    output logic                 push_valid,
    output logic [DATA_BITS-1:0] push_data,
    output logic                 push_frame_err,
    output logic                 push_break
);

    logic                 line_sync;
    logic                 line_fall;
    logic                 char_done;
    logic                 stop_level;
    logic [DATA_BITS-1:0] char_bits;

    uart_rx_sync #(
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .line_async (rx_serial),
        .line_sync  (line_sync),
        .line_fall  (line_fall)
    );

    uart_rx_ctrl #(
        .OVERSAMPLE (OVERSAMPLE),
        .DATA_BITS  (DATA_BITS)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (os_tick),
        .line_sync  (line_sync),
        .line_fall  (line_fall),
        .char_done  (char_done),
        .stop_level (stop_level),
        .char_bits  (char_bits)
    );

    uart_rx_push #(
        .DATA_BITS (DATA_BITS)
    ) u_push (
        .clk        (clk),
        .rst_n      (rst_n),
        .char_done  (char_done),
        .stop_level (stop_level),
        .char_bits  (char_bits),
        .out_valid  (push_valid),
        .out_data   (push_data),
        .out_ferr   (push_frame_err),
        .out_brk    (push_break)
    );

endmodule

// File: rtl/uart_rx_deser_chk.sv
module uart_rx_deser_chk #(
    parameter int DATA_BITS = 8
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 os_tick,
    input logic                 push_valid,
    input logic [DATA_BITS-1:0] push_data,
    input logic                 push_frame_err,
    input logic                 push_break
);

    assert_single_push_R4: assert property (@(posedge clk) disable iff (!rst_n)
        push_valid |=> !push_valid);

    assert_quiet_flags_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !push_valid |-> (!push_frame_err && !push_break));

    assert_break_form_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (push_valid && push_break) |-> (push_frame_err && (push_data == '0)));

    assert_push_after_tick_R8: assert property (@(posedge clk) disable iff (!rst_n)
        push_valid |-> $past(os_tick));

    assert_reset_quiet_R9: assert property (@(posedge clk)
        !rst_n |=> (!push_valid && !push_frame_err && !push_break));

endmodule

bind uart_rx_deser uart_rx_deser_chk #(
    .DATA_BITS (DATA_BITS)
) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .os_tick        (os_tick),
    .push_valid     (push_valid),
    .push_data      (push_data),
    .push_frame_err (push_frame_err),
    .push_break     (push_break)
);

// File: tb/uart_rx_deser_test.sv
module uart_rx_deser_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       os_tick = 1'b0;
    logic       rx_serial = 1'b1;
    logic       push_valid;
    logic [7:0] push_data;
    logic       push_frame_err;
    logic       push_break;

    int n_chk = 0;
    int n_fail = 0;
    int n_push = 0;
    int tdiv = 1;
    int tph = 0;
    bit done = 1'b0;
    logic [7:0] cap_data = '0;
    logic       cap_ferr = 1'b0;
    logic       cap_brk = 1'b0;

    // {data[7:0], stop bit, expected frame error, expected break}
    localparam logic [10:0] VEC [8] = '{
        {8'h55, 1'b1, 1'b0, 1'b0},
        {8'hA3, 1'b1, 1'b0, 1'b0},
        {8'hFF, 1'b1, 1'b0, 1'b0},
        {8'h00, 1'b1, 1'b0, 1'b0},
        {8'h81, 1'b0, 1'b1, 1'b0},
        {8'h00, 1'b0, 1'b1, 1'b1},
        {8'h3C, 1'b1, 1'b0, 1'b0},
        {8'h01, 1'b1, 1'b0, 1'b0}
    };

    uart_rx_deser uut (
        .clk            (clk),
        .rst_n          (rst_n),
        .os_tick        (os_tick),
        .rx_serial      (rx_serial),
        .push_valid     (push_valid),
        .push_data      (push_data),
        .push_frame_err (push_frame_err),
        .push_break     (push_break)
    );

    always #4 clk = ~clk;

    always @(negedge clk) begin
        tph = (tph + 1 >= tdiv) ? 0 : tph + 1;
        os_tick = (tph == 0);
    end

    always @(negedge clk) begin
        if (push_valid) begin
            n_push   = n_push + 1;
            cap_data = push_data;
            cap_ferr = push_frame_err;
            cap_brk  = push_break;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk = n_chk + 1;
        if (act !== exp) begin
            n_fail = n_fail + 1;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic hold_line(input logic lvl, input int clocks);
        rx_serial = lvl;
        repeat (clocks) @(negedge clk);
    endtask

    task automatic send_frame(input logic [7:0] dat, input logic stopb);
        hold_line(1'b0, 16 * tdiv);
        for (int b = 0; b < 8; b++) begin
            hold_line(dat[b], 16 * tdiv);
        end
        hold_line(stopb, 16 * tdiv);
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            n_chk = n_chk + 1;
            n_fail = n_fail + 1;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int base;
        repeat (5) @(negedge clk);
        chk("R9 push_valid in reset", {31'b0, push_valid}, 32'd0);
        chk("R9 flags in reset", {30'b0, push_frame_err, push_break}, 32'd0);
        rst_n = 1'b1;
        hold_line(1'b1, 40);
        chk("R9 no push after reset", n_push, 32'd0);

        // Vector table, first with a tick every clock, then with gapped ticks (R8)
        for (int pass = 0; pass < 2; pass++) begin
            tdiv = (pass == 0) ? 1 : 3;
            hold_line(1'b1, 20);
            for (int i = 0; i < 8; i++) begin
                base = n_push;
                send_frame(VEC[i][10:3], VEC[i][2]);
                if (!VEC[i][2]) begin
                    hold_line(1'b1, 16 * tdiv);
                end
                chk(pass == 0 ? "R4 one push" : "R8 one push gapped tick", n_push - base, 32'd1);
                chk("R3 data", {24'b0, cap_data}, {24'b0, VEC[i][10:3]});
                chk("R5 frame error", {31'b0, cap_ferr}, {31'b0, VEC[i][1]});
                chk("R6 break", {31'b0, cap_brk}, {31'b0, VEC[i][0]});
            end
        end

        // R2 / R1: glitch length boundary, one tick per clock
        tdiv = 1;
        hold_line(1'b1, 30);
        base = n_push;
        hold_line(1'b0, 8);
        hold_line(1'b1, 200);
        chk("R2 8-clock glitch rejected", n_push - base, 32'd0);

        base = n_push;
        hold_line(1'b0, 9);
        hold_line(1'b1, 200);
        chk("R2 9-clock low accepted", n_push - base, 32'd1);
        chk("R1 accepted start data", {24'b0, cap_data}, 32'hFF);
        chk("R5 accepted start stop ok", {31'b0, cap_ferr}, 32'd0);

        // R7: break, line held low, then recovery
        base = n_push;
        send_frame(8'h00, 1'b0);
        hold_line(1'b0, 100);
        chk("R7 single push during held break", n_push - base, 32'd1);
        chk("R6 break flagged", {31'b0, cap_brk}, 32'd1);
        hold_line(1'b1, 32);
        base = n_push;
        send_frame(8'h5A, 1'b1);
        hold_line(1'b1, 16);
        chk("R7 re-armed push", n_push - base, 32'd1);
        chk("R7 re-armed data", {24'b0, cap_data}, 32'h5A);
        chk("R7 re-armed no break", {31'b0, cap_brk}, 32'd0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule